// File: doc/BRIEF.md
# SPI Master with FIFO Watermark Interrupts

This block is a register-mapped SPI master for bursts much longer than its FIFOs. Software loads bytes into a 64-entry transmit FIFO and reads received bytes from a 64-entry receive FIFO. It sets a 24-bit burst length and a 24-bit count of bytes to take from the transmit FIFO, then sets the start bit. The controller asserts chip select and shifts out the queued bytes, followed by zero bytes until the burst length is used up. It captures one MISO byte for every byte it sends.

Software keeps a long burst going by responding to the watermark interrupts. A receive FIFO that is three-quarters full asks to be drained. A transmit FIFO that is three-quarters empty asks to be refilled. A third interrupt marks the end of the burst. The watermark flags are level conditions: writing 1 to clear a flag has no lasting effect while its condition still holds. When pause mode is set, the shifter waits whenever the receive FIFO is full, so a slow interrupt handler cannot lose data.

The serial clock uses SPI mode 0 with MSB first. Its period is `CLK_DIV` system clocks. Register reads return data one cycle after the read strobe.

Top module: `spi_wm_master`

## Requirements
- R1: The level register at 0x28 gives the receive fill level in bits 6:0 and the transmit fill level in bits 22:16. Each level runs from 0 to 64. A write to the transmit data register (0x30) when the transmit FIFO holds 64 bytes is dropped.
- R2: SCLK is low whenever chip select (active low) is high. While chip select is low, each byte appears on MOSI MSB first and is stable at the rising SCLK edge.
- R3: The first N bytes of a burst come from the transmit FIFO, where N is the transmit count register at 0x24. All later bytes of the burst are 0x00. Every byte sampled from MISO is pushed into the receive FIFO, and software reads it from 0x34.
- R4: When the burst count reaches zero, status bit 16 sets, chip select goes high and the start bit (control register 0x04, bit 0) clears.
- R5: Status bit 4 (0x10) sets on every cycle the receive level is 48 or more.
- R6: Status bit 12 sets on every cycle the transmit level is 16 or less. A write-1 clear has no lasting effect while that condition holds.
- R7: Writing 1 to a status bit clears it when its condition is absent. Writing 0 to a status bit leaves it unchanged.
- R8: The irq output goes high one cycle after any status bit is set whose enable bit at 0x0C (bits 4, 12, 16) is also set. irq is low otherwise.
- R9: When pause mode (control bit 18) is set and the receive FIFO is full, no new byte starts. SCLK stays low and chip select stays asserted. Shifting resumes after a read frees space, and no byte is lost.
- R10: When pause mode is clear, a byte that completes while the receive FIFO is full is discarded, and the receive level stays at 64.
- R11: The burst count (0x20) and transmit count (0x24) registers hold 24 bits. Each reads back the number of bytes still to go, and decrements once per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt request |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The hardest state to reach is a burst stalled in pause mode with the receive FIFO full. Reaching it needs more bytes than the FIFO holds, and software must not read any of them. The bench ties MISO back to MOSI and starts a 70-byte pause-mode burst. It polls only the level register until the receive level reads 64. It then watches SCLK and chip select for a long window, and checks that the remaining count stays fixed at 6. Finally it reads ten bytes and checks that the burst finishes with no byte missing.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_CTRL  = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h0C;
  localparam logic [7:0] OFS_ISTS  = 8'h10;
  localparam logic [7:0] OFS_BURST = 8'h20;
  localparam logic [7:0] OFS_XMIT  = 8'h24;
  localparam logic [7:0] OFS_LVL   = 8'h28;
  localparam logic [7:0] OFS_TXD   = 8'h30;
  localparam logic [7:0] OFS_RXD   = 8'h34;

  // bit positions
  localparam int B_START  = 0;
  localparam int B_PAUSE  = 18;
  localparam int B_RXWM   = 4;
  localparam int B_TXWM   = 12;
  localparam int B_DONE   = 16;
  localparam int B_TXLVL  = 16;

  typedef enum logic [2:0] {
    EN_IDLE, EN_GATE, EN_FETCH, EN_LOW, EN_HIGH
  } eng_state_e;

  function automatic logic [31:0] spread_irq(input logic [2:0] v);
    logic [31:0] r;
    r = '0;
    r[B_RXWM] = v[0];
    r[B_TXWM] = v[1];
    r[B_DONE] = v[2];
    return r;
  endfunction

  function automatic logic [2:0] gather_irq(input logic [31:0] w);
    return {w[B_DONE], w[B_TXWM], w[B_RXWM]};
  endfunction
endpackage

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // storage and registered read port, no reset
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
    if (pop_ok)  dout    <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/wm_engine.sv
module wm_engine
  import spi_wm_pkg::*;
#(
  parameter int CLK_DIV = 4,
  localparam int HALF   = CLK_DIV / 2,
  localparam int DCW    = $clog2(HALF + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       pause,
  input  logic       burst_nz,
  input  logic       xmit_nz,
  input  logic       tx_empty,
  input  logic [7:0] tx_data,
  input  logic       rx_full,
  output logic       tx_pop,
  output logic       rx_push,
  output logic [7:0] rx_data,
  output logic       burst_dec,
  output logic       xmit_dec,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  input  logic       miso
);
  eng_state_e st;
  logic [7:0]     sr;
  logic [7:0]     rsr;
  logic [DCW-1:0] dcnt;
  logic [2:0]     bitn;
  logic           go, half_end;

  assign go       = !(pause && rx_full);
  assign half_end = (dcnt == DCW'(HALF - 1));
  assign rx_data  = rsr;

  always_comb begin
    tx_pop    = 1'b0;
    xmit_dec  = 1'b0;
    rx_push   = 1'b0;
    burst_dec = 1'b0;
    done      = 1'b0;
    case (st)
      EN_IDLE: done = start && !burst_nz;
      EN_GATE: begin
        if (!burst_nz) done = 1'b1;
        else if (go && xmit_nz && !tx_empty) begin
          tx_pop   = 1'b1;
          xmit_dec = 1'b1;
        end
      end
      EN_HIGH: if (half_end && bitn == 3'd7) begin
        rx_push   = 1'b1;
        burst_dec = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= EN_IDLE;
      sr   <= '0;
      rsr  <= '0;
      dcnt <= '0;
      bitn <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      cs_n <= 1'b1;
    end else begin
      case (st)
        EN_IDLE: if (start && burst_nz) begin
          st   <= EN_GATE;
          cs_n <= 1'b0;
        end
        EN_GATE: begin
          if (!burst_nz) begin
            st   <= EN_IDLE;
            cs_n <= 1'b1;
            mosi <= 1'b0;
          end else if (go) begin
            if (xmit_nz) begin
              if (!tx_empty) st <= EN_FETCH;
            end else begin
              sr   <= '0;
              mosi <= 1'b0;
              dcnt <= '0;
              bitn <= '0;
              st   <= EN_LOW;
            end
          end
        end
        EN_FETCH: begin
          sr   <= tx_data;
          mosi <= tx_data[7];
          dcnt <= '0;
          bitn <= '0;
          st   <= EN_LOW;
        end
        EN_LOW: begin
          if (half_end) begin
            dcnt <= '0;
            sclk <= 1'b1;
            rsr  <= {rsr[6:0], miso};
            st   <= EN_HIGH;
          end else dcnt <= dcnt + DCW'(1);
        end
        EN_HIGH: begin
          if (half_end) begin
            dcnt <= '0;
            sclk <= 1'b0;
            if (bitn == 3'd7) st <= EN_GATE;
            else begin
              bitn <= bitn + 3'd1;
              sr   <= {sr[6:0], 1'b0};
              mosi <= sr[6];
              st   <= EN_LOW;
            end
          end else dcnt <= dcnt + DCW'(1);
        end
        default: st <= EN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wm_regs.sv
module wm_regs
  import spi_wm_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 24,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int RX_HI = (DEPTH * 3) / 4,
  localparam int TX_LO = DEPTH / 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq,
  output logic             start,
  output logic             pause,
  output logic [2:0]       sts,
  output logic             burst_nz,
  output logic             xmit_nz,
  output logic             tx_push,
  output logic [7:0]       tx_din,
  output logic             rx_pop,
  input  logic [7:0]       rx_dout,
  input  logic [LW-1:0]    rx_lvl,
  input  logic [LW-1:0]    tx_lvl,
  input  logic             done,
  input  logic             burst_dec,
  input  logic             xmit_dec
);
  logic [2:0]       ien;
  logic [CNT_W-1:0] burst, xmit;
  logic [31:0]      rdata_q;
  logic             rdfifo_q;
  logic [2:0]       cond, clr;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[31:24];

  assign cond     = {done, (tx_lvl <= LW'(TX_LO)), (rx_lvl >= LW'(RX_HI))};
  assign clr      = (bus_wr && bus_addr == OFS_ISTS) ? gather_irq(bus_wdata) : 3'b000;
  assign burst_nz = (burst != '0);
  assign xmit_nz  = (xmit != '0);
  assign tx_push  = bus_wr && bus_addr == OFS_TXD;
  assign tx_din   = bus_wdata[7:0];
  assign rx_pop   = bus_rd && bus_addr == OFS_RXD;
  assign bus_rdata = rdfifo_q ? {24'h0, rx_dout} : rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start    <= 1'b0;
      pause    <= 1'b0;
      ien      <= '0;
      sts      <= '0;
      burst    <= '0;
      xmit     <= '0;
      irq      <= 1'b0;
      rdata_q  <= '0;
      rdfifo_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFS_CTRL) begin
        start <= bus_wdata[B_START];
        pause <= bus_wdata[B_PAUSE];
      end
      if (done) start <= 1'b0;
      if (bus_wr && bus_addr == OFS_IEN) ien <= gather_irq(bus_wdata);
      // condition set wins over a same-cycle clear
      sts <= (sts & ~clr) | cond;
      if (bus_wr && bus_addr == OFS_BURST) burst <= bus_wdata[CNT_W-1:0];
      else if (burst_dec)                  burst <= burst - CNT_W'(1);
      if (bus_wr && bus_addr == OFS_XMIT)  xmit <= bus_wdata[CNT_W-1:0];
      else if (xmit_dec)                   xmit <= xmit - CNT_W'(1);
      irq      <= |(sts & ien);
      rdfifo_q <= rx_pop;
      if (bus_rd) begin
        case (bus_addr)
          OFS_CTRL:  rdata_q <= (32'(start) << B_START) | (32'(pause) << B_PAUSE);
          OFS_IEN:   rdata_q <= spread_irq(ien);
          OFS_ISTS:  rdata_q <= spread_irq(sts);
          OFS_BURST: rdata_q <= 32'(burst);
          OFS_XMIT:  rdata_q <= 32'(xmit);
          OFS_LVL:   rdata_q <= 32'(rx_lvl) | (32'(tx_lvl) << B_TXLVL);
          default:   rdata_q <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_wm_master.sv
module spi_wm_master
  import spi_wm_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int CNT_W   = 24,
  parameter int CLK_DIV = 4,
  localparam int LW     = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  logic          ctl_start, ctl_pause, burst_nz, xmit_nz;
  logic [2:0]    sts;
  logic          tx_push, tx_pop, tx_full, tx_empty;
  logic          rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]    tx_din, tx_dout, rx_din, rx_dout;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic          eng_done, burst_dec, xmit_dec;
  logic          unused_flags;

  assign unused_flags = tx_full ^ rx_empty;

  wm_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
    .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .irq,
    .start(ctl_start), .pause(ctl_pause), .sts, .burst_nz, .xmit_nz,
    .tx_push, .tx_din, .rx_pop, .rx_dout, .rx_lvl, .tx_lvl,
    .done(eng_done), .burst_dec, .xmit_dec
  );

  wm_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
    .clk, .rst, .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  wm_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst, .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  wm_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk, .rst, .start(ctl_start), .pause(ctl_pause), .burst_nz, .xmit_nz,
    .tx_empty, .tx_data(tx_dout), .rx_full, .tx_pop, .rx_push, .rx_data(rx_din),
    .burst_dec, .xmit_dec, .done(eng_done), .sclk(spi_sclk), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .miso(spi_miso)
  );
endmodule

// File: rtl/spi_wm_chk.sv
module spi_wm_chk #(
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sclk,
  input logic [LW-1:0] rx_lvl,
  input logic [LW-1:0] tx_lvl,
  input logic          pause,
  input logic          rx_full,
  input logic          rx_push,
  input logic          done,
  input logic          start,
  input logic [2:0]    sts
);
  // R1
  lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl <= LW'(DEPTH)) && (tx_lvl <= LW'(DEPTH)));
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R4
  done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (cs_n && !start && sts[2]));
  // R5
  rxwm_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl >= LW'((DEPTH * 3) / 4)) |=> sts[0]);
  // R6
  txwm_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl <= LW'(DEPTH / 4)) |=> sts[1]);
  // R9
  pause_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pause && rx_full) |-> !rx_push);
endmodule

bind spi_wm_master spi_wm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .pause(ctl_pause), .rx_full(rx_full),
  .rx_push(rx_push), .done(eng_done), .start(ctl_start), .sts(sts)
);

// File: tb/sim_spi_wm_master.sv
`timescale 1ns/1ps
module sim_spi_wm_master;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, sclk, mosi, miso, cs_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] mon_sr;
  int mon_bits, mon_n;
  logic [7:0] mon_b [128];

  always #2 clk = ~clk;
  assign miso = mosi;

  spi_wm_master u0 (
    .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .irq,
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  // serial monitor: capture MOSI at rising SCLK while selected
  always @(posedge sclk) begin
    if (!cs_n) begin
      mon_sr = {mon_sr[6:0], mosi};
      mon_bits++;
      if (mon_bits == 8) begin
        if (mon_n < 128) mon_b[mon_n] = mon_sr;
        mon_n++;
        mon_bits = 0;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mon_clear();
    mon_n = 0; mon_bits = 0; mon_sr = '0;
  endtask

  task automatic wait_burst_end(input string tag);
    int t = 0;
    while (cs_n && t < 200) begin @(negedge clk); t++; end
    while (!cs_n && t < 20000) begin @(negedge clk); t++; end
    chk(cs_n === 1'b1, tag, int'(cs_n), 1);
  endtask

  task automatic drain(input int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) bus_read(8'h34, d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(cs_n === 1'b1 && sclk === 1'b0, "R2 reset pins", {cs_n, sclk}, 2'b10);
    chk(irq === 1'b0, "R8 reset irq", int'(irq), 0);
    bus_read(8'h28, d);
    chk(d == 32'h0, "R1 reset levels", d, 0);
    bus_read(8'h04, d);
    chk(d == 32'h0, "R4 reset ctrl", d, 0);
    bus_read(8'h10, d);
    chk(d == 32'h1000, "R6 empty tx flag", d, 32'h1000);
    bus_write(8'h10, 32'h1000);
    bus_read(8'h10, d);
    chk(d[12] == 1'b1, "R6 flag re-asserts", d[12], 1);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    logic [7:0] exp [5] = '{8'hA5, 8'h3C, 8'h81, 8'h00, 8'h00};
    mon_clear();
    bus_write(8'h30, 32'hA5);
    bus_write(8'h30, 32'h3C);
    bus_write(8'h30, 32'h81);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, d);
    chk(d == 32'h00FF_FFFF, "R11 burst width", d, 32'h00FF_FFFF);
    bus_write(8'h20, 5);
    bus_write(8'h24, 3);
    bus_write(8'h04, 32'h1);
    wait_burst_end("R4 basic cs release");
    chk(mon_n == 5, "R2 byte count", mon_n, 5);
    for (int i = 0; i < 5; i++)
      chk(mon_b[i] == exp[i], "R3 mosi byte", mon_b[i], exp[i]);
    bus_read(8'h28, d);
    chk(d[6:0] == 7'd5, "R3 rx level", d[6:0], 5);
    for (int i = 0; i < 5; i++) begin
      bus_read(8'h34, d);
      chk(d[7:0] == exp[i], "R3 rx data", d[7:0], exp[i]);
    end
    bus_read(8'h10, d);
    chk(d[16] == 1'b1, "R4 done flag", d[16], 1);
    bus_read(8'h04, d);
    chk(d[0] == 1'b0, "R4 start cleared", d[0], 0);
    bus_read(8'h20, d);
    chk(d == 0, "R11 burst left", d, 0);
    bus_read(8'h24, d);
    chk(d == 0, "R11 xmit left", d, 0);
    bus_write(8'h0C, 32'h10000);
    idle(3);
    chk(irq === 1'b1, "R8 irq on done", int'(irq), 1);
    bus_write(8'h10, 32'h0);
    bus_read(8'h10, d);
    chk(d[16] == 1'b1, "R7 write0 keeps", d[16], 1);
    bus_write(8'h10, 32'h10000);
    bus_read(8'h10, d);
    chk(d[16] == 1'b0, "R7 w1c clears", d[16], 0);
    idle(2);
    chk(irq === 1'b0, "R8 irq drops", int'(irq), 0);
    bus_write(8'h0C, 32'h0);
  endtask

  task automatic t_full_tx();
    logic [31:0] d;
    for (int i = 0; i < 66; i++) bus_write(8'h30, 32'((i * 7 + 1) & 8'hFF));
    bus_read(8'h28, d);
    chk(d[22:16] == 7'd64, "R1 tx level cap", d[22:16], 64);
    bus_write(8'h10, 32'h1000);
    bus_read(8'h10, d);
    chk(d[12] == 1'b0, "R7 tx flag clears", d[12], 0);
    bus_write(8'h20, 64);
    bus_write(8'h24, 64);
    bus_write(8'h04, 32'h1);
    wait_burst_end("R4 full burst end");
    bus_read(8'h10, d);
    chk(d[4] == 1'b1, "R5 rx high flag", d[4], 1);
    chk(d[12] == 1'b1, "R6 tx low flag", d[12], 1);
    bus_write(8'h0C, 32'h10);
    idle(3);
    chk(irq === 1'b1, "R8 irq rx", int'(irq), 1);
    for (int i = 0; i < 64; i++) begin
      bus_read(8'h34, d);
      if (i == 0 || i == 63)
        chk(d[7:0] == 8'((i * 7 + 1) & 8'hFF), "R3 rx stream", d[7:0], (i * 7 + 1) & 8'hFF);
    end
    bus_write(8'h10, 32'h10010);
    bus_read(8'h10, d);
    chk(d[4] == 1'b0, "R7 rx flag clears", d[4], 0);
    idle(2);
    chk(irq === 1'b0, "R8 irq rx off", int'(irq), 0);
    bus_write(8'h0C, 32'h0);
  endtask

  task automatic t_pause();
    logic [31:0] d;
    int t = 0;
    logic moved = 1'b0;
    mon_clear();
    bus_write(8'h20, 70);
    bus_write(8'h24, 0);
    bus_write(8'h04, 32'h40001);
    d = 0;
    while (d[6:0] != 7'd64 && t < 200) begin
      idle(50);
      bus_read(8'h28, d);
      t++;
    end
    chk(d[6:0] == 7'd64, "R9 rx filled", d[6:0], 64);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (sclk !== 1'b0 || cs_n !== 1'b0) moved = 1'b1;
    end
    chk(!moved, "R9 stalled pins", int'(moved), 0);
    bus_read(8'h20, d);
    chk(d == 6, "R9 R11 burst left stalled", d, 6);
    drain(10);
    wait_burst_end("R9 resume finish");
    bus_read(8'h28, d);
    chk(d[6:0] == 7'd60, "R9 no byte lost", d[6:0], 60);
    chk(mon_n == 70, "R9 bytes clocked", mon_n, 70);
    drain(60);
    bus_write(8'h10, 32'h10010);
  endtask

  task automatic t_nopause();
    logic [31:0] d;
    mon_clear();
    bus_write(8'h20, 66);
    bus_write(8'h04, 32'h1);
    wait_burst_end("R10 burst end");
    chk(mon_n == 66, "R10 bytes clocked", mon_n, 66);
    bus_read(8'h28, d);
    chk(d[6:0] == 7'd64, "R10 overflow dropped", d[6:0], 64);
    drain(64);
    bus_read(8'h28, d);
    chk(d[6:0] == 7'd0, "R10 drained", d[6:0], 0);
  endtask

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    mon_clear();
    idle(4);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_basic();
    t_full_tx();
    t_pause();
    t_nopause();
    summary();
    $finish;
  end
endmodule